// File: doc/BRIEF.md
# Triggered Capture Core

This block is an in-system logic analyzer. It watches four probe signals. Three are 1-bit flags (`probe_a`, `probe_b`, `probe_c`) and one is a multi-bit field (`probe_d`, `PROBE_D_W` bits wide, 3 by default). The probes are packed into one sample word whose width is the sum of the probe widths. A host talks to the core over a byte link. It sends one command byte to arm the core. When a trigger condition then becomes true, the core writes `DEPTH` consecutive samples into on-chip memory and streams them back to the host, oldest first.

The trigger is a fixed OR of two conditions. The first is `probe_a AND probe_b AND NOT probe_c`. The second is `probe_d == D_MATCH`. The core leaves the armed state on the first clock edge where the trigger is true, and the sample taken at that edge is sample 0.

The byte receive side is a plain valid/data pair and cannot stall. The transmit side is valid/ready:
- The core keeps `tx_valid` high and holds `tx_data` constant until the host asserts `tx_ready`.
- A byte is consumed on every clock edge where both signals are high.
- The host may hold `tx_ready` low for any number of cycles without losing data.

Top module: `trig_capture_core`

## Requirements
- R1: After reset the core is idle and `tx_valid` is low.
- R2: A received byte of value 0x30 arms the core while it is idle. Any other byte value leaves it idle, so a later trigger produces no output.
- R3: While armed, the core starts capturing on the first edge where `(probe_a & probe_b & ~probe_c) | (probe_d == D_MATCH)` holds. While this is false it stays armed and sends nothing.
- R4: Capture stores exactly `DEPTH` samples. The first is the probe value at the trigger edge, and sample k is the probe value k cycles later.
- R5: Sample layout: `probe_a` is bit 0, `probe_b` is bit 1, `probe_c` is bit 2, and `probe_d` occupies bits 3 and up.
- R6: Readout sends samples from address 0 upward. A sample of 8 bits or fewer is sent as one byte with zeroed upper bits. A wider sample is sent as ceil(width/8) bytes, least-significant byte first, with the top byte zero-padded.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged on the next cycle.
- R8: Command bytes received while armed, capturing or reading out are ignored. The capture and readout carry on unchanged, and the core does not re-arm.
- R9: After the last byte is accepted, `tx_valid` falls, the core returns to idle, and it can be armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_a | input | 1 | Probe flag, sample bit 0 |
| probe_b | input | 1 | Probe flag, sample bit 1 |
| probe_c | input | 1 | Probe flag, sample bit 2 |
| probe_d | input | PROBE_D_W | Probe field, sample bits 3 and up |
| rx_valid | input | 1 | Host byte present this cycle |
| rx_data | input | 8 | Host byte value |
| tx_valid | output | 1 | Sample byte available |
| tx_ready | input | 1 | Host accepts the byte this cycle |
| tx_data | output | 8 | Sample byte value |

## Verification
A 6-bit instance and a 10-bit instance run side by side, so both the padded single-byte form and the two-byte least-significant-first form of R6 are checked.

Capture is tried with several input patterns:
- A trigger through the flag condition only, which exercises that condition of the OR on its own.
- A trigger through the field-match condition only, which exercises the other condition on its own.
- A near-miss pattern in which `probe_c` is set and `probe_d` is one away from the match. This separates a correct trigger from a looser one.
- A capture with counting probe values, which makes every sample distinct and so exposes any shifted, reordered or misplaced bit.

A periodic `tx_ready` stall pattern checks that the stream holds its byte under back-pressure. Arming bytes sent in the middle of capture and readout, followed by an unarmed trigger, show that busy-time commands leave no trace.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CAPTURE,
    ST_READOUT
  } la_state_t;

  localparam logic [7:0] ARM_CMD = 8'h30;
endpackage

// File: rtl/la_trigger.sv
module la_trigger #(
  parameter int DW      = 3,
  parameter int D_MATCH = 5
) (
  input  logic          flag_a,
  input  logic          flag_b,
  input  logic          flag_c,
  input  logic [DW-1:0] field_d,
  output logic          hit
);
  localparam int NCOND = 2;

  logic [NCOND-1:0] cond;

  // Each condition is a fixed boolean term; the trigger is their OR.
  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    if (g == 0) begin : g_flags
      assign cond[g] = flag_a & flag_b & ~flag_c;
    end else begin : g_match
      assign cond[g] = (field_d == DW'(D_MATCH));
    end
  end

  assign hit = |cond;
endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
  parameter int SW    = 6,
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);
  logic [SW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  // Read is asynchronous, so the readout needs no prefetch stage.
  assign rdata = store_q[raddr];
endmodule

// File: rtl/la_readout.sv
module la_readout #(
  parameter int SW    = 6,
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [SW-1:0] sample,
  input  logic          tx_ready,
  output logic [AW-1:0] rd_addr,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          last_xfer
);
  localparam int NB = (SW + 7) / 8;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  logic [AW-1:0]   rd_q;
  logic [BW-1:0]   byte_q;
  logic [NB*8-1:0] padded;
  logic            take;
  logic            last_byte;

  always_comb begin
    padded         = '0;
    padded[SW-1:0] = sample;
  end

  if (NB == 1) begin : g_single
    assign tx_data = padded[7:0];
  end else begin : g_multi
    assign tx_data = padded[8*byte_q +: 8];
  end

  assign take      = active & tx_ready;
  assign last_byte = (byte_q == BW'(NB - 1));
  assign last_xfer = take & last_byte & (rd_q == AW'(DEPTH - 1));
  assign tx_valid  = active;
  assign rd_addr   = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      rd_q   <= '0;
      byte_q <= '0;
    end else if (take) begin
      if (last_byte) begin
        byte_q <= '0;
        rd_q   <= rd_q + AW'(1);
      end else begin
        byte_q <= byte_q + BW'(1);
      end
    end
  end
endmodule

// File: rtl/trig_capture_core.sv
module trig_capture_core #(
  parameter int DEPTH     = 4096,
  parameter int PROBE_D_W = 3,
  parameter int D_MATCH   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 probe_a,
  input  logic                 probe_b,
  input  logic                 probe_c,
  input  logic [PROBE_D_W-1:0] probe_d,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data
);
  import la_pkg::*;

  localparam int SW = 3 + PROBE_D_W;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  la_state_t     state_q;
  logic [AW-1:0] wr_addr_q;
  logic          trig_hit;
  logic          wr_en;
  logic [SW-1:0] sample_now;
  logic [SW-1:0] rd_sample;
  logic [AW-1:0] rd_addr;
  logic          last_xfer;
  logic          cmd_arm;

  assign sample_now = {probe_d, probe_c, probe_b, probe_a};
  assign cmd_arm    = rx_valid && (rx_data == ARM_CMD);
  assign wr_en      = (state_q == ST_CAPTURE) || ((state_q == ST_ARMED) && trig_hit);

  la_trigger #(.DW(PROBE_D_W), .D_MATCH(D_MATCH)) u_trig (
    .flag_a (probe_a),
    .flag_b (probe_b),
    .flag_c (probe_c),
    .field_d(probe_d),
    .hit    (trig_hit)
  );

  la_sample_mem #(.SW(SW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr_q),
    .wdata(sample_now),
    .raddr(rd_addr),
    .rdata(rd_sample)
  );

  la_readout #(.SW(SW), .DEPTH(DEPTH), .AW(AW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (state_q == ST_READOUT),
    .sample   (rd_sample),
    .tx_ready (tx_ready),
    .rd_addr  (rd_addr),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .last_xfer(last_xfer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_addr_q <= '0;
    end else begin
      if (wr_en) wr_addr_q <= wr_addr_q + AW'(1);
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_arm) begin
            state_q   <= ST_ARMED;
            wr_addr_q <= '0;
          end
        end
        ST_ARMED: begin
          if (trig_hit) state_q <= (DEPTH == 1) ? ST_READOUT : ST_CAPTURE;
        end
        ST_CAPTURE: begin
          if (wr_addr_q == AW'(DEPTH - 1)) state_q <= ST_READOUT;
        end
        ST_READOUT: begin
          if (last_xfer) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/la_core_checker.sv
module la_core_checker #(
  parameter int SW = 6
) (
  input logic                clk,
  input logic                rst_n,
  input la_pkg::la_state_t   state,
  input logic                trig,
  input logic                rx_valid,
  input logic [7:0]          rx_data,
  input logic                tx_valid,
  input logic                tx_ready,
  input logic [7:0]          tx_data
);
  import la_pkg::*;

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rx_valid && rx_data == ARM_CMD) |=> state == ST_ARMED);

  p_stay_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(rx_valid && rx_data == ARM_CMD)) |=> state == ST_IDLE);

  p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && trig) |=> (state == ST_CAPTURE || state == ST_READOUT));

  p_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !trig) |=> state == ST_ARMED);

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPTURE) |=> (state == ST_CAPTURE || state == ST_READOUT));

  p_readout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READOUT) |=> (state == ST_READOUT || state == ST_IDLE));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  if (SW < 8) begin : g_pad
    p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ((tx_data >> SW) == 8'd0));
  end
endmodule

bind trig_capture_core la_core_checker #(.SW(SW)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (state_q),
  .trig    (trig_hit),
  .rx_valid(rx_valid),
  .rx_data (rx_data),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .tx_data (tx_data)
);

// File: tb/test_trig_capture_core.sv
module test_trig_capture_core;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pa = 1'b0, pb = 1'b0, pc = 1'b0;
  logic [6:0] pd = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_ready = 1'b1;
  logic       n_valid, w_valid;
  logic [7:0] n_data, w_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  byte unsigned q_n[$];
  byte unsigned q_w[$];

  always #2 clk = ~clk;

  trig_capture_core #(.DEPTH(DEPTH), .PROBE_D_W(3), .D_MATCH(5)) i_trig_capture_core (
    .clk(clk), .rst_n(rst_n), .probe_a(pa), .probe_b(pb), .probe_c(pc), .probe_d(pd[2:0]),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(n_valid), .tx_ready(tx_ready), .tx_data(n_data));

  trig_capture_core #(.DEPTH(DEPTH), .PROBE_D_W(7), .D_MATCH(5)) i_trig_capture_core_wide (
    .clk(clk), .rst_n(rst_n), .probe_a(pa), .probe_b(pb), .probe_c(pc), .probe_d(pd),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(w_valid), .tx_ready(tx_ready), .tx_data(w_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: drives tx_ready, pops expected bytes on each transfer.
  bit         n_stall_q = 0, w_stall_q = 0;
  logic [7:0] n_prev = '0, w_prev = '0;
  always @(negedge clk) begin
    cyc++;
    tx_ready = !stall_en || (cyc % 3 == 0);
    if (n_stall_q) chk(n_valid && n_data == n_prev, "R7 narrow hold", int'(n_data), int'(n_prev));
    if (w_stall_q) chk(w_valid && w_data == w_prev, "R7 wide hold", int'(w_data), int'(w_prev));
    if (n_valid && tx_ready) begin
      if (q_n.size() == 0) chk(0, "R2/R8 unexpected narrow byte", int'(n_data), 0);
      else begin
        automatic byte unsigned e = q_n.pop_front();
        chk(n_data == e, "R4/R5/R6 narrow byte", int'(n_data), int'(e));
      end
    end
    if (w_valid && tx_ready) begin
      if (q_w.size() == 0) chk(0, "R2/R8 unexpected wide byte", int'(w_data), 0);
      else begin
        automatic byte unsigned e = q_w.pop_front();
        chk(w_data == e, "R6 wide byte", int'(w_data), int'(e));
      end
    end
    n_stall_q = n_valid && !tx_ready;  n_prev = n_data;
    w_stall_q = w_valid && !tx_ready;  w_prev = w_data;
  end

  task automatic send_cmd(input logic [7:0] v);
    @(negedge clk); rx_valid = 1'b1; rx_data = v;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle_probes(input int n);
    @(negedge clk); pa = 0; pb = 0; pc = 0; pd = '0;
    repeat (n) @(negedge clk);
  endtask

  // Drives DEPTH samples, the first one satisfying the trigger; pushes expectations.
  task automatic run_capture(input bit via_match, input bit expect_out, input bit cmd_mid);
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (via_match) begin pa = 0; pb = 1; pc = 1; pd = 7'd5; end   // R3 field condition
        else begin pa = 1; pb = 1; pc = 0; pd = 7'h6A; end           // R3 flag condition
      end else begin
        pa = k[0]; pb = k[1]; pc = k[2]; pd = 7'(k * 37 + 11);
      end
      rx_valid = cmd_mid && (k == 2);  // R8: command during capture
      rx_data  = 8'h30;
      if (expect_out) begin
        automatic logic [5:0] sn = {pd[2:0], pc, pb, pa};
        automatic logic [9:0] sw = {pd, pc, pb, pa};
        q_n.push_back(byte'({2'b00, sn}));
        q_w.push_back(sw[7:0]);
        q_w.push_back(byte'({6'b0, sw[9:8]}));
      end
    end
    @(negedge clk); rx_valid = 1'b0; pa = 0; pb = 0; pc = 0; pd = '0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 2000 && (q_n.size() != 0 || q_w.size() != 0); i++) @(negedge clk);
    chk(q_n.size() == 0 && q_w.size() == 0, req, q_n.size() + q_w.size(), 0);
    @(negedge clk); @(negedge clk);
    chk(!n_valid && !w_valid, {req, " valid low"}, int'({n_valid, w_valid}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!n_valid && !w_valid, "R1 reset idle", int'({n_valid, w_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!n_valid && !w_valid, "R1 after reset", int'({n_valid, w_valid}), 0);

    // R2: a wrong command byte must not arm
    send_cmd(8'h31);
    run_capture(0, 0, 0);
    idle_probes(30);
    chk(!n_valid && !w_valid, "R2 wrong byte no arm", int'({n_valid, w_valid}), 0);

    // R3/R4/R5/R6: flag-condition trigger, no stalls
    send_cmd(8'h30);
    idle_probes(5);
    run_capture(0, 1, 0);
    drain("R9 first readout");

    // R3 near miss: c set and d off by one keeps the core armed
    send_cmd(8'h30);
    @(negedge clk); pa = 1; pb = 1; pc = 1; pd = 7'd4;
    repeat (10) @(negedge clk);
    chk(!n_valid && !w_valid, "R3 near miss no capture", int'({n_valid, w_valid}), 0);

    // R3 field trigger with stalls (R7) and busy commands (R8)
    stall_en = 1'b1;
    run_capture(1, 1, 1);
    for (int i = 0; i < 100 && !n_valid; i++) @(negedge clk);
    send_cmd(8'h30);  // R8: command during readout
    drain("R8 readout with commands");
    stall_en = 1'b0;
    run_capture(0, 0, 0);  // must not be captured: core not re-armed
    idle_probes(40);
    chk(!n_valid && !w_valid, "R8 no re-arm", int'({n_valid, w_valid}), 0);

    // R9: re-arm after completed readout
    send_cmd(8'h30);
    run_capture(0, 1, 0);
    drain("R9 re-arm readout");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule